// File: doc/BRIEF.md
# Multi-Line Transmit Scanner

This block is the transmit half of a four-line serial multiplexer. All lines share one character data port. A per-line enable register picks the lines that take part. A rotating scanner walks those lines and stops on the first one that is enabled and whose serializer is idle. It then raises a ready flag and shows that line's index. A single data write hands one character to the shown line, and the scan moves on.

Software, or a controller that stands in for it, feeds the block as follows. It waits for the ready flag, or for the interrupt when transmit interrupts are enabled. It then writes one character, which goes to whichever line the scanner is showing. To reach one particular line, software clears the enable bit of any other line that the scanner offers. The serializers are outside the block. Each one reports a busy flag and receives a one-cycle load strobe together with the character.

Top module: `tx_line_scanner`

## Requirements
- R1: After reset `tx_ready`, `tx_irq` and `line_load` are low, `tx_en` is all zeros and `tx_empty` is all ones.
- R2: A cycle with `en_wr` high loads `en_wdata` into `tx_en`, where bit i governs line i. `tx_empty[i]` reads 1 exactly when `tx_en[i]` is 0.
- R3: While no line is offered and `scan_en` is high, the block examines the lines in rotating order, starting after the last offered line. After reset that order starts at line 0. At the next clock edge `tx_ready` rises with `ready_line` set to the first line that is enabled and idle. The offer then holds with a stable `ready_line` until a data write, a disable of that line, or a drop of `scan_en`.
- R4: A `data_wr` while `tx_ready` is high pulses `line_load[ready_line]` in that same cycle, with `line_data` equal to `data_in`. `line_load` has at most one bit set. A `data_wr` while `tx_ready` is low loads no line.
- R5: No line with a clear enable bit is ever offered. Clearing the enable bit of the offered line drops `tx_ready` at the same edge at which `tx_en` changes, and the next scan passes over that line.
- R6: `tx_ready` falls at the clock edge that ends the data-write cycle. A new offer can appear at the following edge at the earliest.
- R7: `tx_irq` is high exactly when `tx_ready` and `tx_int_en` are both high.
- R8: While `scan_en` is low, no new offer is made, and an offer already standing is withdrawn at the next edge.
- R9: The scan skips any enabled line whose `line_busy` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Master enable for the scanner |
| tx_int_en | input | 1 | Transmit interrupt enable |
| en_wr | input | 1 | Write strobe for the line enable register |
| en_wdata | input | NLINES | New line enable value |
| line_busy | input | NLINES | Per-line serializer busy |
| data_wr | input | 1 | Character write strobe |
| data_in | input | DW | Character to send |
| tx_en | output | NLINES | Line enable register |
| tx_empty | output | NLINES | Per-line transmitter-empty status |
| tx_ready | output | 1 | A line is waiting for a character |
| ready_line | output | LW | Index of the offered line |
| tx_irq | output | 1 | Transmit interrupt |
| line_load | output | NLINES | One-hot load strobe to the serializers |
| line_data | output | DW | Character sent to the serializers |

## Verification
The scanner is driven with several enable and busy patterns:
- All lines enabled and idle, which shows the pure rotation and its wrap from line 3 to line 0.
- One line busy, which shows that skipping picks the next candidate rather than stalling.
- The offered line disabled while on offer, which separates withdrawal from a normal write.
- A single enabled line, which shows that the last served line is taken again when it is the only candidate.

Writes made with no offer standing, and periods with `scan_en` low, show that nothing is loaded or offered when the block has not granted a line. A scoreboard pairs each expected line and character with the load strobe that the design actually produces.

// File: rtl/tx_line_scanner.sv
module tx_line_scanner #(
  parameter int NLINES = 4,
  parameter int DW     = 8,
  localparam int LW    = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              tx_int_en,
  input  logic              en_wr,
  input  logic [NLINES-1:0] en_wdata,
  input  logic [NLINES-1:0] line_busy,
  input  logic              data_wr,
  input  logic [DW-1:0]     data_in,
  output logic [NLINES-1:0] tx_en,
  output logic [NLINES-1:0] tx_empty,
  output logic              tx_ready,
  output logic [LW-1:0]     ready_line,
  output logic              tx_irq,
  output logic [NLINES-1:0] line_load,
  output logic [DW-1:0]     line_data
);

  logic [NLINES-1:0] en_q, en_nxt;
  logic              rdy_q;
  logic [LW-1:0]     cur_q, pick;
  logic              found, drop;

  assign en_nxt = en_wr ? en_wdata : en_q;

  always_comb begin
    found = 1'b0;
    pick  = cur_q;
    for (int k = NLINES; k >= 1; k--) begin
      int idx;
      idx = (int'(cur_q) + k) % NLINES;
      if (en_nxt[idx] && !line_busy[idx]) begin
        found = 1'b1;
        pick  = LW'(idx);
      end
    end
  end

  assign drop = !scan_en || data_wr || (en_wr && !en_wdata[cur_q]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      rdy_q <= 1'b0;
      cur_q <= LW'(NLINES - 1);
    end else begin
      en_q <= en_nxt;
      if (rdy_q) begin
        if (drop) rdy_q <= 1'b0;
      end else if (scan_en && found) begin
        rdy_q <= 1'b1;
        cur_q <= pick;
      end
    end
  end

  assign tx_en      = en_q;
  assign tx_empty   = ~en_q;
  assign tx_ready   = rdy_q;
  assign ready_line = cur_q;
  assign tx_irq     = rdy_q & tx_int_en;
  assign line_load  = (data_wr && rdy_q) ? (NLINES'(1) << cur_q) : '0;
  assign line_data  = data_in;

  assert_offer_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_en[ready_line]);

  assert_load_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_load));

  assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_ready) |=> !tx_ready);

  assert_scan_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> !tx_ready);

  assert_offer_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !data_wr && scan_en && !(en_wr && !en_wdata[ready_line]))
      |=> (tx_ready && $stable(ready_line)));

endmodule

// File: tb/tb_tx_line_scanner.sv
module tb_tx_line_scanner;
  localparam int N  = 4;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic scan_en = 0, tx_int_en = 0, en_wr = 0, data_wr = 0;
  logic [N-1:0] en_wdata = '0, line_busy = '0;
  logic [DW-1:0] data_in = '0;
  logic [N-1:0] tx_en, tx_empty, line_load;
  logic tx_ready, tx_irq;
  logic [1:0] ready_line;
  logic [DW-1:0] line_data;

  int n_chk = 0, n_fail = 0;
  logic [9:0] exp_q[$];
  logic done = 0;

  tx_line_scanner #(.NLINES(N), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .tx_int_en(tx_int_en),
    .en_wr(en_wr), .en_wdata(en_wdata), .line_busy(line_busy),
    .data_wr(data_wr), .data_in(data_in), .tx_en(tx_en), .tx_empty(tx_empty),
    .tx_ready(tx_ready), .ready_line(ready_line), .tx_irq(tx_irq),
    .line_load(line_load), .line_data(line_data));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic set_en(input logic [N-1:0] v);
    en_wr = 1; en_wdata = v; step; en_wr = 0;
  endtask

  task automatic wr_char(input int ln, input logic [DW-1:0] d);
    chk(tx_ready == 1, "R3 offer", tx_ready, 1);
    chk(int'(ready_line) == ln, "R3 line", ready_line, ln);
    exp_q.push_back({ln[1:0], d});
    data_wr = 1; data_in = d;
    step;
    data_wr = 0;
    chk(tx_ready == 0, "R6 ready clears", tx_ready, 0);
    chk(tx_irq == 0, "R7 no irq", tx_irq, 0);
    step;
  endtask

  always @(negedge clk) begin
    if (line_load != '0) begin
      if (exp_q.size() == 0) begin
        chk(0, "R4 unexpected load", line_load, 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk(line_load == (N'(1) << e[9:8]), "R4 load line", line_load, N'(1) << e[9:8]);
        chk(line_data == e[7:0], "R4 load data", line_data, e[7:0]);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_ln;
    step; step;
    rst_n = 1;
    #2;
    chk(tx_ready == 0, "R1 ready", tx_ready, 0);
    chk(tx_en == 0, "R1 en", tx_en, 0);
    chk(tx_empty == 4'hF, "R1 empty", tx_empty, 4'hF);
    chk(tx_irq == 0, "R1 irq", tx_irq, 0);
    chk(line_load == 0, "R1 load", line_load, 0);
    step;

    scan_en = 1;
    set_en(4'b1111);
    chk(tx_empty == 4'b0000, "R2 empty", tx_empty, 0);
    chk(tx_en == 4'b1111, "R2 en", tx_en, 4'hF);
    chk(tx_ready && ready_line == 0, "R3 first line 0", ready_line, 0);
    chk(tx_irq == 0, "R7 irq masked", tx_irq, 0);
    tx_int_en = 1; #1;
    chk(tx_irq == 1, "R7 irq", tx_irq, 1);

    wr_char(0, 8'hA5);
    line_busy = 4'b0100;
    wr_char(1, 8'h3C);
    chk(tx_ready && ready_line == 3, "R9 skip busy", ready_line, 3);
    line_busy = 4'b0000;

    set_en(4'b0111);
    chk(tx_ready == 0, "R5 withdraw", tx_ready, 0);
    chk(tx_empty == 4'b1000, "R2 empty after clear", tx_empty, 4'b1000);
    step;
    chk(tx_ready && ready_line == 0, "R5 moves on", ready_line, 0);

    set_en(4'b0000);
    chk(tx_ready == 0, "R5 all off", tx_ready, 0);
    data_wr = 1; data_in = 8'h77; #1;
    chk(line_load == 0, "R4 write ignored", line_load, 0);
    step; data_wr = 0; step;
    chk(tx_ready == 0, "R5 none offered", tx_ready, 0);

    scan_en = 0;
    set_en(4'b0010);
    step; step;
    chk(tx_ready == 0, "R8 scan off", tx_ready, 0);
    scan_en = 1; step;
    chk(tx_ready && ready_line == 1, "R8 scan resumes", ready_line, 1);
    scan_en = 0; step;
    chk(tx_ready == 0, "R8 withdraw", tx_ready, 0);
    scan_en = 1; step;
    chk(tx_ready && ready_line == 1, "R3 sole line again", ready_line, 1);

    set_en(4'b1111);
    exp_ln = 1;
    for (int i = 0; i < 6; i++) begin
      wr_char(exp_ln, 8'(8'h10 + i));
      exp_ln = (exp_ln + 1) % N;
    end
    step; step;
    chk(exp_q.size() == 0, "R4 all loads seen", exp_q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule